// File: doc/BRIEF.md
# Packed Lane Adder/Subtractor with Saturation

This block adds or subtracts two 64-bit words that are treated as vectors of equal-width integer elements. The element width can be 8, 16, 32 or 64 bits. Every element pair is computed on its own, and no carry or borrow passes from one element into the next. Subtraction takes the second operand away from the first.

Each element result is produced in one of three ways. Wraparound keeps only the low bits of the true result. Signed saturation clamps the result to the signed range of the element. Unsigned saturation clamps the result to the range from zero to the all-ones value. The two saturating ways are available only for 8-bit and 16-bit elements.

A caller presents the operands and controls together with `valid_i`. The result is registered and appears one cycle later, marked by `valid_o`.

Top module: `packed_addsub`

## Requirements
- R1: With `mode_i` = 0 and `sub_i` = 0, each element of `res_o` is the sum of the matching elements of `a_i` and `b_i`. `size_i` selects the element width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Element k occupies bits [k*W +: W].
- R2: With `sub_i` = 1, each element result is `a_i` element minus `b_i` element.
- R3: In wraparound mode (`mode_i` = 0), an element whose sum or difference overflows or underflows keeps only its low W bits. For example, 0xFF + 0x01 in an 8-bit element gives 0x00.
- R4: In signed saturation (`mode_i` = 1) with `size_i` of 0 or 1, a result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1).
- R5: In unsigned saturation (`mode_i` = 2) with `size_i` of 0 or 1, a result above 2^W-1 becomes 2^W-1, and a result below 0 becomes 0.
- R6: A saturating mode combined with `size_i` of 2 or 3 behaves as wraparound. `mode_i` = 3 behaves as wraparound at every size.
- R7: No carry or borrow crosses an element boundary in any mode.
- R8: `res_o` and `valid_o` update one cycle after an edge where `valid_i` = 1. `valid_o` equals the `valid_i` of the previous cycle. `res_o` holds its value when `valid_i` = 0.
- R9: A synchronous active-high `rst` clears `valid_o` and `res_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operands and controls are valid |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| size_i | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| mode_i | input | 2 | 0 wrap, 1 signed saturate, 2 unsigned saturate, 3 wrap |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| res_o | output | 64 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after valid_i |

## Verification
Two functions can fall in the same cycle: the carry that ripples between byte slices inside one element, and the clamp that replaces the whole element. Both are provoked by 16-bit corner operands such as 0x7FFF+0x0001 and 0x00FF+0xFFFF. In these, a low-byte carry must enter the upper byte and then be overridden by the clamp across both bytes. An exhaustive 8-bit sweep places eight different pairs in each word, so clamped lanes sit beside wrapping neighbours. Every vector is judged lane by lane against an arithmetic model in the bench.

// File: rtl/paddsub_pkg.sv
package paddsub_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP = 2'd0,
    MODE_SSAT = 2'd1,
    MODE_USAT = 2'd2,
    MODE_WRP2 = 2'd3
  } mode_e;

  // element-size codes below this value allow saturation
  localparam int unsigned SAT_SIZE_LIMIT = 2;
endpackage

// File: rtl/padd_byte_slice.sv
module padd_byte_slice #(
  parameter int unsigned SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               inv,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout,
  output logic               ovf_s
);
  logic [SLICE_W-1:0] bx;
  logic [SLICE_W:0]   full;

  always_comb begin
    bx   = inv ? ~b : b;
    full = {1'b0, a} + {1'b0, bx} + {{SLICE_W{1'b0}}, cin};
    sum  = full[SLICE_W-1:0];
    cout = full[SLICE_W];
    // signed overflow: same-sign inputs with a result of the other sign
    ovf_s = (a[SLICE_W-1] == bx[SLICE_W-1]) && (full[SLICE_W-1] != a[SLICE_W-1]);
  end
endmodule

// File: rtl/padd_lane_clamp.sv
module padd_lane_clamp #(
  parameter int unsigned SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] sum,
  input  logic               is_top,
  input  logic               sat_s,
  input  logic               sat_u,
  input  logic               sub,
  input  logic               lane_a_msb,
  input  logic               lane_ovf_s,
  input  logic               lane_cout,
  output logic [SLICE_W-1:0] out
);
  logic               u_hit;
  logic [SLICE_W-1:0] s_val;
  logic [SLICE_W-1:0] u_val;

  always_comb begin
    // add overflows on carry out; subtract underflows when no carry (borrow)
    u_hit = sub ? ~lane_cout : lane_cout;
    u_val = sub ? '0 : '1;
    if (lane_a_msb)
      s_val = is_top ? {1'b1, {(SLICE_W-1){1'b0}}} : '0;
    else
      s_val = is_top ? {1'b0, {(SLICE_W-1){1'b1}}} : '1;
    if (sat_s && lane_ovf_s)
      out = s_val;
    else if (sat_u && u_hit)
      out = u_val;
    else
      out = sum;
  end
endmodule

// File: rtl/packed_addsub.sv
module packed_addsub
  import paddsub_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        mode_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              valid_o
);
  localparam int unsigned NB    = DATA_W / SLICE_W;
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0]     cin, cout, ovf, amsb, start;
  logic [DATA_W-1:0] sum, nxt;
  logic [IDX_W-1:0]  lane_mask;
  logic              sat_s, sat_u;

  always_comb begin
    lane_mask = IDX_W'((1 << size_i) - 1);
    sat_s = (mode_i == MODE_SSAT) && (32'(size_i) < SAT_SIZE_LIMIT);
    sat_u = (mode_i == MODE_USAT) && (32'(size_i) < SAT_SIZE_LIMIT);
  end

  for (genvar i = 0; i < NB; i++) begin : g_slice
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic [IDX_W-1:0] top_idx;
    logic             is_top;

    assign start[i] = ((IDX & lane_mask) == '0);
    assign top_idx  = IDX | lane_mask;
    assign is_top   = (top_idx == IDX);
    assign amsb[i]  = a_i[SLICE_W*i + SLICE_W-1];

    if (i == 0) begin : g_first
      assign cin[i] = sub_i;
    end else begin : g_rest
      assign cin[i] = start[i] ? sub_i : cout[i-1];
    end

    padd_byte_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a     (a_i[SLICE_W*i +: SLICE_W]),
      .b     (b_i[SLICE_W*i +: SLICE_W]),
      .inv   (sub_i),
      .cin   (cin[i]),
      .sum   (sum[SLICE_W*i +: SLICE_W]),
      .cout  (cout[i]),
      .ovf_s (ovf[i])
    );

    padd_lane_clamp #(.SLICE_W(SLICE_W)) u_clamp (
      .sum        (sum[SLICE_W*i +: SLICE_W]),
      .is_top     (is_top),
      .sat_s      (sat_s),
      .sat_u      (sat_u),
      .sub        (sub_i),
      .lane_a_msb (amsb[top_idx]),
      .lane_ovf_s (ovf[top_idx]),
      .lane_cout  (cout[top_idx]),
      .out        (nxt[SLICE_W*i +: SLICE_W])
    );

    // R7: in 8-bit wrap add each byte is its own sum, untouched by neighbours
    assert_lane_carry_R7: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i == 2'd0 && mode_i == 2'd0 && !sub_i) |=>
      res_o[SLICE_W*i +: SLICE_W] ==
        SLICE_W'($past(a_i[SLICE_W*i +: SLICE_W]) + $past(b_i[SLICE_W*i +: SLICE_W])));

    // R5: unsigned saturating add never drops below the first operand
    assert_usat_floor_R5: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i == 2'd0 && mode_i == 2'd2 && !sub_i) |=>
      res_o[SLICE_W*i +: SLICE_W] >= $past(a_i[SLICE_W*i +: SLICE_W]));

    // R4: signed saturating add of two non-negative bytes stays non-negative
    assert_ssat_sign_R4: assert property (@(posedge clk) disable iff (rst)
      (valid_i && size_i == 2'd0 && mode_i == 2'd1 && !sub_i &&
       !a_i[SLICE_W*i + SLICE_W-1] && !b_i[SLICE_W*i + SLICE_W-1]) |=>
      !res_o[SLICE_W*i + SLICE_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= nxt;
    end
  end

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && $stable(res_o)));
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!valid_o && res_o == '0));
endmodule

// File: tb/sim_packed_addsub.sv
module sim_packed_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  size_i = '0, mode_i = '0;
  logic        sub_i = 1'b0;
  logic [63:0] res_o;
  logic        valid_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  packed_addsub u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .size_i(size_i), .mode_i(mode_i), .sub_i(sub_i),
    .res_o(res_o), .valid_o(valid_o)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic [1:0] sz, logic [1:0] md, logic sb);
    int w, n;
    bit sat;
    logic [63:0] r;
    logic [67:0] mask;
    w = 8 << sz;
    n = 64 / w;
    sat = (sz < 2) && (md == 2'd1 || md == 2'd2);
    mask = (68'd1 << w) - 68'd1;
    r = '0;
    for (int l = 0; l < n; l++) begin
      logic [67:0] ua, ub;
      logic signed [67:0] sa, sbv, x, hi, lo;
      ua = (68'(a) >> (l * w)) & mask;
      ub = (68'(b) >> (l * w)) & mask;
      sa  = ua[w-1] ? $signed(ua) - $signed(68'd1 << w) : $signed(ua);
      sbv = ub[w-1] ? $signed(ub) - $signed(68'd1 << w) : $signed(ub);
      if (sat && md == 2'd1) begin
        x  = sb ? sa - sbv : sa + sbv;
        hi = $signed((68'd1 << (w - 1)) - 68'd1);
        lo = -$signed(68'd1 << (w - 1));
        if (x > hi) x = hi;
        if (x < lo) x = lo;
      end else if (sat && md == 2'd2) begin
        x  = sb ? $signed(ua) - $signed(ub) : $signed(ua) + $signed(ub);
        hi = $signed(mask);
        if (x > hi) x = hi;
        if (x < 0) x = '0;
      end else begin
        x = sb ? $signed(ua - ub) : $signed(ua + ub);
      end
      r = r | 64'((68'(x) & mask) << (l * w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] sz, logic [1:0] md, logic sb);
    if (md == 2'd3 || (md != 2'd0 && sz >= 2)) return "R6";
    if (md == 2'd1) return "R4";
    if (md == 2'd2) return "R5";
    return sb ? "R2" : "R1";
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                     logic [1:0] md, logic sb, string tag);
    logic [63:0] exp;
    @(negedge clk);
    a_i = a; b_i = b; size_i = sz; mode_i = md; sub_i = sb; valid_i = 1'b1;
    exp = model(a, b, sz, md, sb);
    @(negedge clk);
    check({tag, " valid (R8)"}, {63'd0, valid_o}, 64'd1);
    check(tag, res_o, exp);
  endtask

  initial begin
    logic [63:0] last;
    repeat (3) @(negedge clk);
    check("R9 reset result", res_o, 64'd0);
    check("R9 reset valid", {63'd0, valid_o}, 64'd0);
    rst = 1'b0;

    // R3: wrap overflow and underflow at the byte level
    run({8{8'hFF}}, {8{8'h01}}, 2'd0, 2'd0, 1'b0, "R3");
    run({8{8'h00}}, {8{8'h01}}, 2'd0, 2'd0, 1'b1, "R3");
    // R7: all-ones plus one per lane, every size, no spill into neighbours
    for (int s = 0; s < 4; s++) begin
      logic [63:0] one;
      one = '0;
      for (int k = 0; k < 64; k += (8 << s)) one[k] = 1'b1;
      run('1, one, 2'(s), 2'd0, 1'b0, "R7");
      run('0, one, 2'(s), 2'd0, 1'b1, "R7");
      run('1, one, 2'(s), 2'd2, 1'b0, (s < 2) ? "R5" : "R6");
    end
    // 16-bit corners: inner carry and clamp in the same lane
    run({4{16'h7FFF}}, {4{16'h0001}}, 2'd1, 2'd1, 1'b0, "R4");
    run({4{16'h8000}}, {4{16'h0001}}, 2'd1, 2'd1, 1'b1, "R4");
    run({4{16'h00FF}}, {4{16'hFFFF}}, 2'd1, 2'd2, 1'b0, "R5");
    run({4{16'h0100}}, {4{16'h0101}}, 2'd1, 2'd2, 1'b1, "R5");
    run({2{32'h7FFFFFFF}}, {2{32'h1}}, 2'd2, 2'd1, 1'b0, "R6");
    run(64'h7FFFFFFFFFFFFFFF, 64'h1, 2'd3, 2'd1, 1'b0, "R6");

    // exhaustive 8-bit sweep: eight pairs per vector
    for (int md = 0; md < 4; md++)
      for (int sb = 0; sb < 2; sb++)
        for (int v = 0; v < 8192; v++) begin
          logic [63:0] a, b;
          for (int k = 0; k < 8; k++) begin
            logic [15:0] p;
            p = 16'(v * 8 + k);
            a[8*k +: 8] = p[15:8];
            b[8*k +: 8] = p[7:0];
          end
          run(a, b, 2'd0, 2'(md), 1'(sb), tag_of(2'd0, 2'(md), 1'(sb)));
        end

    // random vectors at the wider sizes
    for (int s = 1; s < 4; s++)
      for (int md = 0; md < 4; md++)
        for (int sb = 0; sb < 2; sb++)
          for (int v = 0; v < 300; v++)
            run({$urandom, $urandom}, {$urandom, $urandom}, 2'(s), 2'(md), 1'(sb),
                tag_of(2'(s), 2'(md), 1'(sb)));

    // R8: result holds and valid drops while valid_i is low
    last = res_o;
    @(negedge clk);
    valid_i = 1'b0; a_i = 64'h0123456789ABCDEF; b_i = '1;
    @(negedge clk);
    check("R8 hold result", res_o, last);
    check("R8 valid low", {63'd0, valid_o}, 64'd0);

    // R9: reset during operation
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset", res_o, 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule